// File: doc/BRIEF.md
# Channel-Status Bit Generator

This block produces the channel-status bit that goes into each subframe of a two-channel digital audio transmitter. Subframes arrive one at a time on a valid/ready stream. Each carries one serially supplied status bit. The stream alternates strictly between channel A and channel B, starting with A after reset. For each subframe the block works out the bit's position inside the 192-bit status block and derives a generated value for that position. The generated value comes from active-low dedicated control pins, a two-bit code and, in professional operation, an internal CRC. The block ORs this value with the serial bit and emits the result together with the channel and the position.

There are three ways of working. Professional mode is selected with `consumer_sel` low. Consumer mode is selected with `consumer_sel` high, and it has a compact-disc submode in which the serial input is masked. In transparent mode every generated contribution is dropped and the serial bit passes through untouched.

The input stream follows back-pressure in the usual way. A transfer happens on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Once the output is valid, it holds steady until `out_ready` takes it. Each accepted subframe appears at the output on the following cycle.

Top module: `cs_bit_gen`

## Requirements
- R1: After reset the first accepted subframe is channel A at position 0. Channels then alternate A, B, A, and so on. The position advances by one after each channel B subframe and wraps from 191 to 0.
- R2: Outside transparent mode, position 0 carries 1 in professional mode and 0 in consumer mode, unless the serial bit is 1.
- R3: In professional mode, positions 1, 6, 7 and 9 carry the inverse of `fix_n[0]`, `fix_n[1]`, `fix_n[2]` and `fix_n[3]` respectively. `fix_n[4]` has no effect in this mode.
- R4: In professional mode, `rate_code` selects the emphasis pattern for positions 2, 3 and 4 (listed in that order): 00 gives 1,1,1; 01 gives 1,1,0; 10 gives 0,0,0; 11 gives 1,0,0.
- R5: In consumer mode, positions 2, 3, 8, 9 and 15 carry the inverse of `fix_n[0]` through `fix_n[4]` respectively. `rate_code` drives positions 24 and 25 (in that order): 00 gives 0,0; 01 gives 0,1; 10 gives 1,1; 11 gives 0,0.
- R6: In consumer mode with `rate_code` = 11 (compact-disc submode), the serial bit is ignored. The output equals the pin-derived value, and all positions without a pin are 0.
- R7: Outside transparent mode, the serial bit is ORed into every position, including position 0 and the CRC positions. Positions with no generated value output only the serial bit.
- R8: In professional mode, positions 184 to 191 carry the CRC of that channel's transmitted positions 0 to 183, ORed with the serial bit. The CRC uses polynomial x^8+x^4+x^3+x^2+1. Its register is preset to all ones at position 0 and fed one bit per position, in position order. Each step is fb = bit XOR r[7]; r = (r<<1) XOR (fb ? 0x1D : 0). Position 184+k carries r[k].
- R9: In transparent mode, the output bit equals the serial bit for every position. All pins and codes have no effect.
- R10: `in_ready` is high whenever `out_valid` is low. A valid output holds its bit, channel and position while `out_ready` is low. After reset `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restarts the block position |
| consumer_sel | input | 1 | 0 = professional, 1 = consumer |
| transparent | input | 1 | 1 = pass the serial bit through unchanged |
| fix_n | input | 5 | Active-low dedicated status pins |
| rate_code | input | 2 | Emphasis code (professional) or rate code (consumer) |
| in_valid | input | 1 | Subframe present on input |
| in_ready | output | 1 | Block can take a subframe |
| in_c | input | 1 | Serial status bit for this subframe |
| out_valid | output | 1 | Result present on output |
| out_ready | input | 1 | Downstream takes the result |
| out_c | output | 1 | Merged status bit |
| out_chan_b | output | 1 | 0 = channel A, 1 = channel B |
| out_idx | output | 8 | Position 0..191 inside the status block |

## Verification
The assertions assume that the mode, pin and code inputs stay constant between resets. They also assume that `in_c` is stable for as long as a subframe waits to be accepted. The bench changes these inputs only while reset is held, and it changes `in_c` only together with a new `in_valid` decision. Both `in_valid` and `out_ready` are driven with irregular patterns, so stalls and back-to-back transfers both occur, and every run passes the 191-to-0 wrap in each mode.

// File: rtl/cs_gen_pkg.sv
package cs_gen_pkg;

  typedef enum logic [1:0] {
    CSM_PRO   = 2'd0,
    CSM_CONS  = 2'd1,
    CSM_CD    = 2'd2,
    CSM_TRANS = 2'd3
  } cs_mode_e;

  // Emphasis pattern: [0] -> position 2, [1] -> position 3, [2] -> position 4
  function automatic logic [2:0] emph_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 3'b111;
      2'b01:   return 3'b011;
      2'b10:   return 3'b000;
      default: return 3'b001;
    endcase
  endfunction

  // Rate field: [0] -> position 24, [1] -> position 25
  function automatic logic [1:0] rate_bits(input logic [1:0] code);
    case (code)
      2'b01:   return 2'b10;
      2'b10:   return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/cs_index_track.sv
module cs_index_track #(
  parameter int BLOCK_BITS = 192,
  localparam int IDX_W = $clog2(BLOCK_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic             chan_b,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BLOCK_BITS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_b <= 1'b0;
      idx    <= '0;
    end else if (adv) begin
      chan_b <= ~chan_b;
      if (chan_b) idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end
endmodule

// File: rtl/cs_pin_map.sv
module cs_pin_map
  import cs_gen_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  cs_mode_e         mode,
  input  logic [IDX_W-1:0] idx,
  input  logic [4:0]       fix_n,
  input  logic [1:0]       rate_code,
  output logic             pin_bit
);
  logic [2:0]  emph;
  logic [1:0]  rate;
  int unsigned pos;

  assign emph = emph_bits(rate_code);
  assign rate = rate_bits(rate_code);

  always_comb begin
    pos     = 32'(idx);
    pin_bit = 1'b0;
    case (mode)
      CSM_PRO: begin
        case (pos)
          0:       pin_bit = 1'b1;
          1:       pin_bit = ~fix_n[0];
          2:       pin_bit = emph[0];
          3:       pin_bit = emph[1];
          4:       pin_bit = emph[2];
          6:       pin_bit = ~fix_n[1];
          7:       pin_bit = ~fix_n[2];
          9:       pin_bit = ~fix_n[3];
          default: pin_bit = 1'b0;
        endcase
      end
      CSM_CONS, CSM_CD: begin
        case (pos)
          2:       pin_bit = ~fix_n[0];
          3:       pin_bit = ~fix_n[1];
          8:       pin_bit = ~fix_n[2];
          9:       pin_bit = ~fix_n[3];
          15:      pin_bit = ~fix_n[4];
          24:      pin_bit = rate[0];
          25:      pin_bit = rate[1];
          default: pin_bit = 1'b0;
        endcase
      end
      default: pin_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cs_crc_gen.sv
module cs_crc_gen #(
  parameter int                BLOCK_BITS = 192,
  parameter int                CRC_BITS   = 8,
  parameter logic [CRC_BITS-1:0] CRC_POLY = 8'h1D,
  localparam int IDX_W     = $clog2(BLOCK_BITS),
  localparam int CRC_IW    = $clog2(CRC_BITS),
  localparam int CRC_START = BLOCK_BITS - CRC_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             chan_b,
  input  logic [IDX_W-1:0] idx,
  input  logic             bit_in,
  output logic             crc_bit
);
  logic [1:0][CRC_BITS-1:0] crc_all;
  logic                     in_body;
  logic                     in_tail;
  logic [CRC_IW-1:0]        off;

  assign in_body = (idx < IDX_W'(CRC_START));
  assign in_tail = ~in_body;
  assign off     = CRC_IW'(idx - IDX_W'(CRC_START));

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [CRC_BITS-1:0] crc_q;
    logic [CRC_BITS-1:0] base;
    logic                fb;

    assign base = (idx == '0) ? '1 : crc_q;
    assign fb   = bit_in ^ base[CRC_BITS-1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        crc_q <= '1;
      end else if (adv && (chan_b == 1'(ch)) && in_body) begin
        crc_q <= {base[CRC_BITS-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      end
    end

    assign crc_all[ch] = crc_q;
  end

  assign crc_bit = in_tail & crc_all[chan_b][off];
endmodule

// File: rtl/cs_bit_gen.sv
module cs_bit_gen
  import cs_gen_pkg::*;
#(
  parameter int                  BLOCK_BITS = 192,
  parameter int                  CRC_BITS   = 8,
  parameter logic [CRC_BITS-1:0] CRC_POLY   = 8'h1D
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          consumer_sel,
  input  logic                          transparent,
  input  logic [4:0]                    fix_n,
  input  logic [1:0]                    rate_code,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic                          in_c,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic                          out_c,
  output logic                          out_chan_b,
  output logic [$clog2(BLOCK_BITS)-1:0] out_idx
);
  localparam int IDX_W = $clog2(BLOCK_BITS);

  cs_mode_e         mode;
  logic             accept;
  logic             chan_b;
  logic [IDX_W-1:0] idx;
  logic             pin_bit;
  logic             crc_bit;
  logic             ser_bit;
  logic             cs_bit;

  always_comb begin
    if (transparent)       mode = CSM_TRANS;
    else if (!consumer_sel) mode = CSM_PRO;
    else if (rate_code == 2'b11) mode = CSM_CD;
    else                   mode = CSM_CONS;
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  cs_index_track #(.BLOCK_BITS(BLOCK_BITS)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (accept),
    .chan_b (chan_b),
    .idx    (idx)
  );

  cs_pin_map #(.IDX_W(IDX_W)) u_map (
    .mode      (mode),
    .idx       (idx),
    .fix_n     (fix_n),
    .rate_code (rate_code),
    .pin_bit   (pin_bit)
  );

  cs_crc_gen #(
    .BLOCK_BITS (BLOCK_BITS),
    .CRC_BITS   (CRC_BITS),
    .CRC_POLY   (CRC_POLY)
  ) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (accept),
    .chan_b  (chan_b),
    .idx     (idx),
    .bit_in  (cs_bit),
    .crc_bit (crc_bit)
  );

  assign ser_bit = (mode == CSM_CD) ? 1'b0 : in_c;
  assign cs_bit  = (mode == CSM_TRANS) ? in_c
                 : (ser_bit | pin_bit | ((mode == CSM_PRO) & crc_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_c      <= 1'b0;
      out_chan_b <= 1'b0;
      out_idx    <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_c      <= cs_bit;
      out_chan_b <= chan_b;
      out_idx    <= idx;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/cs_bit_gen_chk.sv
module cs_bit_gen_chk #(
  parameter int BLOCK_BITS = 192,
  localparam int IDX_W = $clog2(BLOCK_BITS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             consumer_sel,
  input logic             transparent,
  input logic [1:0]       rate_code,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_c,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_c,
  input logic             out_chan_b,
  input logic [IDX_W-1:0] out_idx
);
  logic             seen;
  logic             last_chan;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] next_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      last_chan <= 1'b0;
      last_idx  <= '0;
    end else if (out_valid && out_ready) begin
      seen      <= 1'b1;
      last_chan <= out_chan_b;
      last_idx  <= out_idx;
    end
  end

  assign next_idx = (last_idx == IDX_W'(BLOCK_BITS - 1)) ? '0 : last_idx + 1'b1;

  assert_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !seen) |-> (!out_chan_b && out_idx == '0));

  assert_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen) |-> (out_chan_b != last_chan) &&
      (out_chan_b ? (out_idx == last_idx) : (out_idx == next_idx)));

  assert_bit0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx == '0 && !consumer_sel && !transparent) |-> out_c);

  assert_cd_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && consumer_sel && rate_code == 2'b11 && !transparent &&
     out_idx == IDX_W'(100)) |-> !out_c);

  assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && transparent) |=> (out_c == $past(in_c)));

  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_c) &&
      $stable(out_chan_b) && $stable(out_idx)));
endmodule

bind cs_bit_gen cs_bit_gen_chk #(.BLOCK_BITS(BLOCK_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .consumer_sel (consumer_sel),
  .transparent  (transparent),
  .rate_code    (rate_code),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_c         (in_c),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_c        (out_c),
  .out_chan_b   (out_chan_b),
  .out_idx      (out_idx)
);

// File: tb/test_cs_bit_gen.sv
module test_cs_bit_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       consumer_sel = 1'b0;
  logic       transparent = 1'b0;
  logic [4:0] fix_n = 5'h1F;
  logic [1:0] rate_code = 2'b00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_c = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic       out_c;
  logic       out_chan_b;
  logic [7:0] out_idx;

  int tests = 0;
  int fails = 0;

  typedef struct {
    int    c;
    int    ch;
    int    idx;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   m_ch, m_idx;
  int   m_crc[2];
  int   ser_mode;

  cs_bit_gen i_cs_bit_gen (
    .clk(clk), .rst_n(rst_n), .consumer_sel(consumer_sel),
    .transparent(transparent), .fix_n(fix_n), .rate_code(rate_code),
    .in_valid(in_valid), .in_ready(in_ready), .in_c(in_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_c(out_c),
    .out_chan_b(out_chan_b), .out_idx(out_idx)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // Behavioural expectation for one accepted subframe
  function automatic exp_t model_step(input int c);
    exp_t e;
    int   g, fb, b;
    bit   cons, cd;
    int   em[3];
    int   fr[2];
    cons = consumer_sel;
    cd   = cons && rate_code == 2'b11;
    g    = 0;
    e.tag = "R7";
    if (m_idx == 0) m_crc[m_ch] = 255;
    case (rate_code)
      2'b00: em = '{1, 1, 1};
      2'b01: em = '{1, 1, 0};
      2'b10: em = '{0, 0, 0};
      default: em = '{1, 0, 0};
    endcase
    case (rate_code)
      2'b01: fr = '{0, 1};
      2'b10: fr = '{1, 1};
      default: fr = '{0, 0};
    endcase
    if (!cons) begin
      if (m_idx == 0) begin g = 1; e.tag = "R2"; end
      if (m_idx == 1) begin g = !fix_n[0]; e.tag = "R3"; end
      if (m_idx >= 2 && m_idx <= 4) begin g = em[m_idx-2]; e.tag = "R4"; end
      if (m_idx == 6) begin g = !fix_n[1]; e.tag = "R3"; end
      if (m_idx == 7) begin g = !fix_n[2]; e.tag = "R3"; end
      if (m_idx == 9) begin g = !fix_n[3]; e.tag = "R3"; end
      if (m_idx >= 184) begin g = (m_crc[m_ch] >> (m_idx - 184)) & 1; e.tag = "R8"; end
    end else begin
      if (m_idx == 0) e.tag = "R2";
      if (m_idx == 2) begin g = !fix_n[0]; e.tag = "R5"; end
      if (m_idx == 3) begin g = !fix_n[1]; e.tag = "R5"; end
      if (m_idx == 8) begin g = !fix_n[2]; e.tag = "R5"; end
      if (m_idx == 9) begin g = !fix_n[3]; e.tag = "R5"; end
      if (m_idx == 15) begin g = !fix_n[4]; e.tag = "R5"; end
      if (m_idx == 24) begin g = fr[0]; e.tag = "R5"; end
      if (m_idx == 25) begin g = fr[1]; e.tag = "R5"; end
      if (cd) e.tag = "R6";
    end
    b = (cd ? 0 : c) | g;
    if (transparent) begin
      b = c;
      e.tag = "R9";
    end
    if (m_idx < 184) begin
      fb = b ^ ((m_crc[m_ch] >> 7) & 1);
      m_crc[m_ch] = ((m_crc[m_ch] << 1) & 255) ^ (fb != 0 ? 'h1D : 0);
    end
    e.c   = b;
    e.ch  = m_ch;
    e.idx = m_idx;
    if (m_ch == 1) m_idx = (m_idx == 191) ? 0 : m_idx + 1;
    m_ch = 1 - m_ch;
    return e;
  endfunction

  task automatic do_reset(input bit cons, input bit trn, input logic [4:0] fx,
                          input logic [1:0] code, input int smode);
    in_valid  = 1'b0;
    out_ready = 1'b0;
    rst_n     = 1'b0;
    consumer_sel = cons;
    transparent  = trn;
    fix_n     = fx;
    rate_code = code;
    ser_mode  = smode;
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready, "R10", {out_valid, in_ready}, 1);
    rst_n = 1'b1;
    m_ch = 0;
    m_idx = 0;
    m_crc = '{255, 255};
    exp_q.delete();
  endtask

  task automatic run_phase(input int n);
    int   sent = 0;
    int   outs = 0;
    bit   p_in_acc = 0, p_out_acc = 0;
    int   p_in_c = 0, p_c = 0, p_ch = 0, p_idx = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (p_in_acc) exp_q.push_back(model_step(p_in_c));
      if (p_out_acc) begin
        outs++;
        if (exp_q.size() == 0) begin
          chk(0, "R10", outs, sent);
        end else begin
          e = exp_q.pop_front();
          chk(p_c == e.c, e.tag, p_c, e.c);
          chk(p_ch == e.ch && p_idx == e.idx, "R1", p_ch * 1000 + p_idx, e.ch * 1000 + e.idx);
        end
      end
      if (sent == n && exp_q.size() == 0 && !out_valid && !p_in_acc) break;
      in_valid  = (sent < n) && ($urandom % 4 != 0);
      case (ser_mode)
        0: in_c = 1'b0;
        1: in_c = ($urandom % 8 == 0);
        2: in_c = 1'b1;
        default: in_c = $urandom % 2;
      endcase
      out_ready = ($urandom % 3 != 0);
      #1;
      p_in_acc  = in_valid && in_ready;
      p_out_acc = out_valid && out_ready;
      p_in_c    = in_c;
      p_c       = out_c;
      p_ch      = out_chan_b;
      p_idx     = out_idx;
      if (p_in_acc) sent++;
    end
    in_valid = 1'b0;
    chk(outs == n, "R10", outs, n);
  endtask

  initial begin
    // R3 R4 R7: professional, mixed pins, sparse serial bits
    do_reset(0, 0, 5'b10101, 2'b01, 1);  run_phase(400);
    // R8: professional, all pins asserted, no serial bits; CRC visible
    do_reset(0, 0, 5'b00000, 2'b10, 0);  run_phase(400);
    do_reset(0, 0, 5'b11111, 2'b11, 0);  run_phase(400);
    // R5 R7: consumer modes
    do_reset(1, 0, 5'b01010, 2'b01, 1);  run_phase(400);
    do_reset(1, 0, 5'b10100, 2'b10, 3);  run_phase(400);
    // R6: compact-disc submode with serial bits all high
    do_reset(1, 0, 5'b00000, 2'b11, 2);  run_phase(400);
    // R9: transparent, pins that would otherwise set bits
    do_reset(0, 1, 5'b00000, 2'b00, 3);  run_phase(400);
    // R1 R2: long professional run across two wraps
    do_reset(0, 0, 5'b01100, 2'b00, 1);  run_phase(800);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule